// File: doc/BRIEF.md
# Per-Thread Scratch Register Arithmetic Unit

This block is the arithmetic and logic stage of a command engine that runs several hardware threads. Each thread owns a private bank of four 32-bit scratch registers. One instruction may be presented per clock. It names a thread, a destination register, an opcode and two operands. Each operand is either a register of that same thread or a 16-bit immediate. The unit evaluates the operation and stores the 32-bit result in the destination register.

A separate load form writes a full 32-bit constant straight into a scratch register. Firmware uses that form to build values, masks or upper address halves that do not fit in an immediate. A combinational read port lets the surrounding engine inspect any register of any thread.

Top module: `thr_alu`

## Requirements
- R1: After reset every scratch register of every thread reads as zero, and `bad_op` is low.
- R2: Threads share index values 0..3 but have separate storage. An instruction for one thread leaves the registers of every other thread unchanged.
- R3: When `in_valid` and `in_load` are both high, `in_const` is written unchanged into register `in_dst` of thread `in_thread`. The opcode and operand fields are then ignored.
- R4: For each operand, flag = 1 selects register number `field[1:0]` of the instruction's thread, and flag = 0 selects the 16-bit field zero-extended to 32 bits.
- R5: Opcode 1 adds, 2 subtracts (left minus right) and 3 multiplies. Each keeps the low 32 bits of the result.
- R6: Opcode 8 is bitwise XOR, 10 is bitwise OR and 11 is bitwise AND of the two operands.
- R7: Opcode 9 returns the bitwise inverse of the right operand and ignores the left operand.
- R8: Opcode 12 shifts the left operand left, and opcode 13 shifts it right. Both shifts are logical and shift by the right operand's bits [4:0].
- R9: Opcode 0 copies the right operand into the destination.
- R10: Opcodes 4..7 and 14..15 leave the destination unchanged and raise `bad_op` for exactly the one cycle after the instruction's clock edge.
- R11: A result is visible on the read port in the cycle after the edge that accepts the instruction. While `in_valid` is low, no register changes.
- R12: `rd_data` shows register `rd_idx` of thread `rd_thread` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_thread | input | 2 | Thread the instruction belongs to |
| in_dst | input | 2 | Destination register index |
| in_load | input | 1 | 1 = load full constant, 0 = operate |
| in_const | input | 32 | Constant for the load form |
| in_op | input | 4 | Opcode |
| in_lhs_reg | input | 1 | Left operand is a register index |
| in_lhs | input | 16 | Left operand field |
| in_rhs_reg | input | 1 | Right operand is a register index |
| in_rhs | input | 16 | Right operand field |
| rd_thread | input | 2 | Inspection thread |
| rd_idx | input | 2 | Inspection register index |
| rd_data | output | 32 | Inspected register contents |
| bad_op | output | 1 | One-cycle unused-opcode pulse |

## Verification
The assertions check four things on every cycle: the banks hold still when no instruction arrives, other threads' banks stay untouched, a load lands exactly, and an unused opcode both raises the flag and preserves its destination. The arithmetic results themselves can only be shown by the bench's scenarios. Those scenarios cover wrap-around in add, subtract and multiply, shift amounts above 31, NOT with a nonzero left operand, immediate zero extension, and register operands reading values written in the previous cycle.

// File: rtl/thr_alu_pkg.sv
package thr_alu_pkg;

    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_MUL = 4'd3,
        OP_XOR = 4'd8,
        OP_INV = 4'd9,
        OP_IOR = 4'd10,
        OP_AND = 4'd11,
        OP_SHL = 4'd12,
        OP_SHR = 4'd13
    } alu_op_e;

    function automatic logic op_is_legal(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9,
            4'd10, 4'd11, 4'd12, 4'd13: op_is_legal = 1'b1;
            default:                    op_is_legal = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/thr_alu_opsel.sv
module thr_alu_opsel #(
    parameter int NREG = 4,
    parameter int DW   = 32,
    parameter int IW   = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][DW-1:0] row,
    input  logic                    is_reg,
    input  logic [IW-1:0]           field,
    output logic [DW-1:0]           value
);
    logic [RW-1:0] sel;

    always_comb begin
        sel = field[RW-1:0];
        if (is_reg) begin
            value = row[sel];
        end else begin
            value = '0;
            value[IW-1:0] = field;
        end
    end
endmodule

// File: rtl/thr_alu_exec.sv
module thr_alu_exec
    import thr_alu_pkg::*;
#(
    parameter int DW = 32,
    localparam int SW = $clog2(DW)
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          legal
);
    logic [SW-1:0] amt;

    always_comb begin
        amt   = b[SW-1:0];
        legal = op_is_legal(op);
        case (op)
            OP_MOV:  res = b;
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  res = a * b;
            OP_XOR:  res = a ^ b;
            OP_INV:  res = ~b;
            OP_IOR:  res = a | b;
            OP_AND:  res = a & b;
            OP_SHL:  res = a << amt;
            OP_SHR:  res = a >> amt;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/thr_alu.sv
module thr_alu
    import thr_alu_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int NREG = 4,
    parameter int DW   = 32,
    parameter int IW   = 16,
    localparam int TW  = $clog2(NTHR),
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [TW-1:0] in_thread,
    input  logic [RW-1:0] in_dst,
    input  logic          in_load,
    input  logic [DW-1:0] in_const,
    input  logic [3:0]    in_op,
    input  logic          in_lhs_reg,
    input  logic [IW-1:0] in_lhs,
    input  logic          in_rhs_reg,
    input  logic [IW-1:0] in_rhs,
    input  logic [TW-1:0] rd_thread,
    input  logic [RW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          bad_op
);
    typedef struct packed {
        logic [NTHR-1:0][NREG-1:0][DW-1:0] regs;
        logic                              bad;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0][DW-1:0] cur_row;
    logic [DW-1:0]           lhs_val, rhs_val, alu_res;
    logic                    alu_legal;

    assign cur_row = st_q.regs[in_thread];

    thr_alu_opsel #(.NREG(NREG), .DW(DW), .IW(IW)) u_lhs (
        .row(cur_row), .is_reg(in_lhs_reg), .field(in_lhs), .value(lhs_val)
    );

    thr_alu_opsel #(.NREG(NREG), .DW(DW), .IW(IW)) u_rhs (
        .row(cur_row), .is_reg(in_rhs_reg), .field(in_rhs), .value(rhs_val)
    );

    thr_alu_exec #(.DW(DW)) u_exec (
        .op(in_op), .a(lhs_val), .b(rhs_val), .res(alu_res), .legal(alu_legal)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (in_valid) begin
            if (in_load) begin
                st_d.regs[in_thread][in_dst] = in_const;
            end else if (alu_legal) begin
                st_d.regs[in_thread][in_dst] = alu_res;
            end else begin
                st_d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.regs[rd_thread][rd_idx];
    assign bad_op  = st_q.bad;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(st_q.regs));                                  // R11
    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_load) |->
        st_q.regs[$past(in_thread)][$past(in_dst)] == $past(in_const));             // R3
    AST_BAD_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> $past(in_valid && !in_load && !op_is_legal(in_op)));             // R10
    AST_BAD_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !in_load && !op_is_legal(in_op)) |->
        (bad_op && $stable(st_q.regs)));                                            // R10

    for (genvar t = 0; t < NTHR; t++) begin : g_iso
        AST_OTHER_THREAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(in_thread) != TW'(t)) |-> $stable(st_q.regs[t]));                 // R2
    end
endmodule

// File: tb/sim_thr_alu.sv
module sim_thr_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_thread = '0, in_dst = '0, rd_thread = '0, rd_idx = '0;
    logic        in_load = 1'b0, in_lhs_reg = 1'b0, in_rhs_reg = 1'b0;
    logic [31:0] in_const = '0;
    logic [3:0]  in_op = '0;
    logic [15:0] in_lhs = '0, in_rhs = '0;
    logic [31:0] rd_data;
    logic        bad_op;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] model [4][4];
    int sweep = 0;

    always #5 clk = ~clk;

    thr_alu u0 (.*);

    function automatic logic [31:0] ref_op(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            0:  return b;
            1:  return a + b;
            2:  return a - b;
            3:  return a * b;
            8:  return a ^ b;
            9:  return ~b;
            10: return a | b;
            11: return a & b;
            12: return a << (b % 32);
            13: return a >> (b % 32);
            default: return 32'hx;
        endcase
    endfunction

    function automatic bit ref_legal(int op);
        return (op <= 3) || (op >= 8 && op <= 13);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(string tag, int t, int i);
        rd_thread = 2'(t);
        rd_idx    = 2'(i);
        #1;
        check(tag, rd_data, model[t][i]);
    endtask

    task automatic after_edge(string tag, bit exp_bad);
        @(posedge clk);
        #1;
        check({tag, " R10 flag"}, {31'd0, bad_op}, {31'd0, exp_bad});
        peek({tag, " R2 sweep"}, sweep / 4, sweep % 4);
        sweep = (sweep + 1) % 16;
    endtask

    task automatic do_load(int t, int d, logic [31:0] c, string tag);
        in_valid = 1'b1; in_load = 1'b1; in_thread = 2'(t); in_dst = 2'(d);
        in_const = c; in_op = 4'd5;
        model[t][d] = c;
        after_edge(tag, 1'b0);
        in_valid = 1'b0; in_load = 1'b0;
        peek({tag, " R3 dst"}, t, d);
    endtask

    task automatic do_op(int t, int d, int op, bit lr, logic [15:0] lv,
                         bit rr, logic [15:0] rv, string tag);
        logic [31:0] a, b;
        bit ok;
        a = lr ? model[t][lv % 4] : {16'd0, lv};
        b = rr ? model[t][rv % 4] : {16'd0, rv};
        ok = ref_legal(op);
        in_valid = 1'b1; in_load = 1'b0; in_thread = 2'(t); in_dst = 2'(d);
        in_op = 4'(op); in_lhs_reg = lr; in_lhs = lv; in_rhs_reg = rr; in_rhs = rv;
        in_const = 32'hDEAD_BEEF;
        if (ok) model[t][d] = ref_op(op, a, b);
        after_edge(tag, !ok);
        in_valid = 1'b0;
        peek({tag, " dst"}, t, d);
    endtask

    task automatic idle(string tag);
        in_valid = 1'b0; in_load = 1'b1; in_const = 32'h1234_5678;
        in_op = 4'd1;
        after_edge({tag, " R11 idle"}, 1'b0);
        in_load = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 4; i++) model[t][i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 bad_op", {31'd0, bad_op}, 32'd0);
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 4; i++) peek("R1 reset", t, i);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R3 loads, R2 separate banks with same index
        do_load(0, 1, 32'hFFFF_FFFF, "R3 load t0");
        do_load(1, 1, 32'h8000_0001, "R3 load t1");
        do_load(2, 1, 32'h0000_0007, "R3 load t2");
        peek("R2 t0 kept", 0, 1);
        peek("R2 t3 untouched", 3, 1);

        // R11: idle cycles keep everything
        idle("idle a");
        idle("idle b");

        // R9 assign from immediate and from register
        do_op(0, 0, 0, 1'b0, 16'h0, 1'b0, 16'hABCD, "R9 mov imm");
        do_op(1, 2, 0, 1'b0, 16'h0, 1'b1, 16'hFFF1, "R9 R4 mov reg upper bits ignored");

        // R5 wrap
        do_op(0, 2, 1, 1'b1, 16'd1, 1'b0, 16'd1, "R5 add wrap");
        do_op(0, 3, 2, 1'b0, 16'd0, 1'b0, 16'd1, "R5 sub wrap");
        do_op(1, 3, 3, 1'b1, 16'd1, 1'b1, 16'd1, "R5 mul wrap");
        do_op(2, 0, 3, 1'b0, 16'hFFFF, 1'b0, 16'hFFFF, "R5 R4 mul imm zero ext");

        // R6 bitwise
        do_op(0, 2, 8, 1'b1, 16'd1, 1'b0, 16'h00FF, "R6 xor");
        do_op(0, 3, 10, 1'b1, 16'd0, 1'b0, 16'hF000, "R6 or");
        do_op(1, 0, 11, 1'b1, 16'd1, 1'b0, 16'hFFFF, "R6 and");

        // R7 not ignores left
        do_op(2, 2, 9, 1'b1, 16'd1, 1'b0, 16'h00F0, "R7 not");
        do_op(2, 3, 9, 1'b0, 16'h5555, 1'b1, 16'd1, "R7 not reg rhs");

        // R8 shifts, amount low 5 bits
        do_op(1, 2, 13, 1'b1, 16'd1, 1'b0, 16'd31, "R8 shr 31");
        do_op(1, 3, 12, 1'b1, 16'd1, 1'b0, 16'd33, "R8 shl 33 -> 1");
        do_op(0, 1, 13, 1'b1, 16'd1, 1'b0, 16'd36, "R8 shr 36 -> 4");
        do_op(2, 1, 12, 1'b1, 16'd1, 1'b1, 16'd1, "R8 shl by reg");

        // R10 unused opcodes, including back-to-back
        do_op(0, 1, 4, 1'b0, 16'd1, 1'b0, 16'd1, "R10 op4");
        do_op(0, 1, 7, 1'b0, 16'd1, 1'b0, 16'd1, "R10 op7");
        do_op(3, 0, 14, 1'b0, 16'd9, 1'b0, 16'd9, "R10 op14");
        do_op(3, 0, 15, 1'b0, 16'd9, 1'b0, 16'd9, "R10 op15");
        idle("R10 flag drops");

        // R11 back-to-back dependent writes, R12 read port
        do_op(3, 1, 1, 1'b0, 16'd100, 1'b0, 16'd23, "R11 chain a");
        do_op(3, 2, 1, 1'b1, 16'd1, 1'b1, 16'd1, "R11 chain b");
        do_op(3, 3, 2, 1'b1, 16'd2, 1'b0, 16'd7, "R11 chain c");

        // mixed pseudo-random sequence
        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom_range(0, 15));
            if (($urandom % 5) == 0)
                do_load(int'($urandom % 4), int'($urandom % 4), 32'($urandom), "R3 rnd load");
            else
                do_op(int'($urandom % 4), int'($urandom % 4), op,
                      1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom), "R4 rnd");
        end

        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 4; i++) peek("R12 final", t, i);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule